// File: doc/BRIEF.md
# Privilege-Gated Counter CSR Unit

This block keeps the free-running cycle counter and the retired-instruction counter of a hart, together with two 32-bit masks that grant lower privilege levels read access to the counters. The pipeline issues reads and writes on a single CSR port and supplies the current privilege mode. The block returns read data one cycle later. When a gated counter view is read from a mode that lacks permission, it raises a one-cycle illegal-access flag so that the trap logic can act.

A counter view is identified by the low five bits of its CSR address. Permission for a view is the AND of the masks of every privilege level above the current mode. Machine mode therefore sees everything, supervisor mode needs the machine mask bit, and user mode needs both the machine and the supervisor mask bits. Performance counters 3 to 31, their upper halves and their event selectors are not implemented and always read as zero.

Top module: `ctr_gate_csr`

## Requirements
- R1: The machine grant mask (CSR 0x306) and the supervisor grant mask (CSR 0x106) are 32 bits wide. Each reads back exactly the value last written to it, and any mode may read either of them.
- R2: When the mode is machine (encoding 3), no counter read raises the illegal flag, whatever the masks hold.
- R3: When the mode is supervisor (1) or the reserved encoding 2, a read of a gated view (0xC00–0xC1F, and 0xC80–0xC9F when XLEN is 32) is allowed only if bit addr[4:0] of the machine grant mask is set.
- R4: When the mode is user (0), a gated view is allowed only if bit addr[4:0] is set in both the machine mask and the supervisor mask.
- R5: A denied read sets csr_illegal high for exactly the one cycle after the read strobe, and csr_rdata is zero in that cycle.
- R6: Read data is registered. It is valid in the cycle after csr_re, it shows the value held before that clock edge, and it is zero in cycles that follow no read strobe.
- R7: The cycle counter (0xB00, user view 0xC00) adds one on every clock once reset has ended. The retired-instruction counter (0xB02, user view 0xC02) adds one for each cycle in which retire is high.
- R8: A CSR write to a counter in the same cycle as its increment takes priority, and the written value is kept unchanged.
- R9: When XLEN is 32, a write to 0xB80 or 0xB82 replaces bits 63:32 and keeps bits 31:0. A write to 0xB00 or 0xB02 replaces bits 31:0 and keeps bits 63:32. The upper halves read at 0xB80/0xB82 and 0xC80/0xC82, and a carry out of bit 31 reaches bit 32.
- R10: Performance counters 0xB03–0xB1F and 0xC03–0xC1F, and their upper halves 0xB83–0xB9F and 0xC83–0xC9F, read as zero when the access is allowed. Index 1 (the time view) also reads as zero.
- R11: Event selectors 0x323–0x33F read as zero, and writes to them change nothing.
- R12: After reset all counters and both masks are zero and the outputs are low. Internal state leaves reset on the second clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the current access |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| priv | input | 2 | Current mode: 0 user, 1 supervisor, 3 machine |
| retire | input | 1 | One instruction retired this cycle |
| csr_rdata | output | XLEN | Registered read data |
| csr_illegal | output | 1 | Registered one-cycle denied-access flag |

## Verification
Directed sequences walk all four mode encodings against masks in which only selected bits are set. This separates a gate that ANDs both masks from one that looks at a single mask, and shows whether the right address bits choose the index. Writes that coincide with a retire pulse, and a low word set to all ones, separate write priority from increment and show the carry into the upper half. Random mixes of modes, mask writes and addresses across the gated views, the unimplemented counters and the event selectors are then compared against a model built from the requirements.

// File: rtl/ctrgate_pkg.sv
package ctrgate_pkg;

  localparam int CW = 64;

  localparam logic [1:0] MODE_USER  = 2'd0;
  localparam logic [1:0] MODE_SUPER = 2'd1;
  localparam logic [1:0] MODE_MACH  = 2'd3;

  localparam logic [11:0] ADR_MGRANT = 12'h306;
  localparam logic [11:0] ADR_SGRANT = 12'h106;
  localparam logic [11:0] ADR_CYC_LO = 12'hB00;
  localparam logic [11:0] ADR_RET_LO = 12'hB02;
  localparam logic [11:0] ADR_CYC_HI = 12'hB80;
  localparam logic [11:0] ADR_RET_HI = 12'hB82;

  localparam logic [6:0] BLK_MACH_LO = 7'(12'hB00 >> 5);
  localparam logic [6:0] BLK_MACH_HI = 7'(12'hB80 >> 5);
  localparam logic [6:0] BLK_USER_LO = 7'(12'hC00 >> 5);
  localparam logic [6:0] BLK_USER_HI = 7'(12'hC80 >> 5);

  localparam logic [4:0] IDX_CYC = 5'd0;
  localparam logic [4:0] IDX_RET = 5'd2;

endpackage

// File: rtl/ctrgate_rst_sync.sv
module ctrgate_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ni = stage_q[1];
endmodule

// File: rtl/ctrgate_grants.sv
module ctrgate_grants
  import ctrgate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        we_m,
  input  logic        we_s,
  input  logic [31:0] wdata,
  input  logic [1:0]  priv,
  output logic [31:0] mgrant,
  output logic [31:0] sgrant,
  output logic [31:0] allow
);
  logic [31:0] mg_q, mg_d, sg_q, sg_d;

  always_comb begin
    mg_d = mg_q;
    sg_d = sg_q;
    if (we_m) mg_d = wdata;
    if (we_s) sg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mg_q <= '0;
      sg_q <= '0;
    end else begin
      if (we_m) mg_q <= mg_d;
      if (we_s) sg_q <= sg_d;
    end
  end

  always_comb begin
    allow = '1;
    if (priv < MODE_MACH)  allow = allow & mg_q;
    if (priv < MODE_SUPER) allow = allow & sg_q;
  end

  assign mgrant = mg_q;
  assign sgrant = sg_q;

  // R1
  mgrant_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    we_m |=> mgrant == $past(wdata));
  // R1
  sgrant_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    we_s |=> sgrant == $past(wdata));
endmodule

// File: rtl/ctrgate_counter.sv
module ctrgate_counter
  import ctrgate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            inc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wdata,
  output logic [CW-1:0]   count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  generate
    if (XLEN == 32) begin : g_split
      always_comb begin
        cnt_d = cnt_q;
        if (wr_lo)      cnt_d = {cnt_q[CW-1:32], wdata};
        else if (wr_hi) cnt_d = {wdata, cnt_q[31:0]};
        else if (inc)   cnt_d = cnt_q + 1'b1;
      end
    end else begin : g_full
      always_comb begin
        cnt_d = cnt_q;
        if (wr_lo)    cnt_d = CW'(wdata);
        else if (inc) cnt_d = cnt_q + 1'b1;
      end
    end
  endgenerate

  assign cnt_en = inc | wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (inc && !wr_lo && !wr_hi) |=> count == $past(count) + 1'b1);
  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!inc && !wr_lo && !wr_hi) |=> $stable(count));
  // R8
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_lo |=> count[XLEN-1:0] == $past(wdata));
endmodule

// File: rtl/ctrgate_rdmux.sv
module ctrgate_rdmux
  import ctrgate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0]     addr,
  input  logic [31:0]     mgrant,
  input  logic [31:0]     sgrant,
  input  logic [CW-1:0]   cyc,
  input  logic [CW-1:0]   ret,
  output logic [XLEN-1:0] data,
  output logic            gated
);
  localparam bit HAS_HI = (XLEN == 32);

  logic [6:0]    blk;
  logic [4:0]    idx;
  logic [CW-1:0] raw;

  assign blk = addr[11:5];
  assign idx = addr[4:0];

  always_comb begin
    raw   = '0;
    gated = 1'b0;
    if (addr == ADR_MGRANT) begin
      raw = {32'b0, mgrant};
    end else if (addr == ADR_SGRANT) begin
      raw = {32'b0, sgrant};
    end else if (blk == BLK_MACH_LO || blk == BLK_USER_LO) begin
      gated = (blk == BLK_USER_LO);
      if (idx == IDX_CYC)      raw = cyc;
      else if (idx == IDX_RET) raw = ret;
    end else if (HAS_HI && (blk == BLK_MACH_HI || blk == BLK_USER_HI)) begin
      gated = (blk == BLK_USER_HI);
      if (idx == IDX_CYC)      raw = {32'b0, cyc[CW-1:32]};
      else if (idx == IDX_RET) raw = {32'b0, ret[CW-1:32]};
    end
  end

  assign data = raw[XLEN-1:0];
endmodule

// File: rtl/ctr_gate_csr.sv
module ctr_gate_csr
  import ctrgate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic            csr_re,
  input  logic [1:0]      priv,
  input  logic            retire,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal
);
  localparam bit HAS_HI = (XLEN == 32);

  logic            rst_ni;
  logic [31:0]     mgrant, sgrant, allow;
  logic [CW-1:0]   cyc, ret;
  logic [XLEN-1:0] mux_data;
  logic            mux_gated;
  logic            we_m, we_s, cyc_lo, cyc_hi, ret_lo, ret_hi;
  logic [XLEN-1:0] rdata_q, rdata_d;
  logic            ill_q, ill_d;

  ctrgate_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  assign we_m   = csr_we && (csr_addr == ADR_MGRANT);
  assign we_s   = csr_we && (csr_addr == ADR_SGRANT);
  assign cyc_lo = csr_we && (csr_addr == ADR_CYC_LO);
  assign ret_lo = csr_we && (csr_addr == ADR_RET_LO);
  assign cyc_hi = HAS_HI && csr_we && (csr_addr == ADR_CYC_HI);
  assign ret_hi = HAS_HI && csr_we && (csr_addr == ADR_RET_HI);

  ctrgate_grants u_grants (
    .clk(clk), .rst_ni(rst_ni), .we_m(we_m), .we_s(we_s),
    .wdata(csr_wdata[31:0]), .priv(priv),
    .mgrant(mgrant), .sgrant(sgrant), .allow(allow)
  );

  ctrgate_counter #(.XLEN(XLEN)) u_cyc (
    .clk(clk), .rst_ni(rst_ni), .inc(1'b1), .wr_lo(cyc_lo), .wr_hi(cyc_hi),
    .wdata(csr_wdata), .count(cyc)
  );

  ctrgate_counter #(.XLEN(XLEN)) u_ret (
    .clk(clk), .rst_ni(rst_ni), .inc(retire), .wr_lo(ret_lo), .wr_hi(ret_hi),
    .wdata(csr_wdata), .count(ret)
  );

  ctrgate_rdmux #(.XLEN(XLEN)) u_mux (
    .addr(csr_addr), .mgrant(mgrant), .sgrant(sgrant), .cyc(cyc), .ret(ret),
    .data(mux_data), .gated(mux_gated)
  );

  always_comb begin
    ill_d   = csr_re && mux_gated && !allow[csr_addr[4:0]];
    rdata_d = '0;
    if (csr_re && !ill_d) rdata_d = mux_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ill_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ill_q   <= ill_d;
    end
  end

  assign csr_rdata   = rdata_q;
  assign csr_illegal = ill_q;

  // R2
  mach_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_re && priv == MODE_MACH) |=> !csr_illegal);
  // R5
  ill_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    csr_illegal |-> csr_rdata == '0);
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !csr_re |=> (csr_rdata == '0 && !csr_illegal));
  // R11
  evsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (csr_re && csr_addr >= 12'h323 && csr_addr <= 12'h33F) |=> csr_rdata == '0);
endmodule

// File: tb/sim_ctr_gate_csr.sv
`timescale 1ns/1ps
module sim_ctr_gate_csr;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata;
  logic            csr_we, csr_re, retire;
  logic [1:0]      priv;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  ctr_gate_csr #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_re(csr_re), .priv(priv), .retire(retire),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  // Reference model derived from the requirements
  logic [1:0]  s_q;
  logic [63:0] m_cyc, m_ret;
  logic [31:0] m_mg, m_sg;
  logic [31:0] e_rdata;
  logic        e_ill;

  function automatic logic [31:0] f_allow(input logic [1:0] pv, input logic [31:0] mg, sg);
    logic [31:0] a = '1;
    if (pv != 2'd3) a = a & mg;   // R3: every mode below machine needs the machine bit
    if (pv == 2'd0) a = a & sg;   // R4: user also needs the supervisor bit
    return a;
  endfunction

  function automatic logic [31:0] f_data(input logic [11:0] a, input logic [63:0] c, r,
                                         input logic [31:0] mg, sg);
    logic [4:0] i = a[4:0];
    if (a == 12'h306) return mg;
    if (a == 12'h106) return sg;
    if ((a >= 12'hB00 && a <= 12'hB1F) || (a >= 12'hC00 && a <= 12'hC1F))
      return (i == 0) ? c[31:0] : (i == 2) ? r[31:0] : 32'h0;
    if ((a >= 12'hB80 && a <= 12'hB9F) || (a >= 12'hC80 && a <= 12'hC9F))
      return (i == 0) ? c[63:32] : (i == 2) ? r[63:32] : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic f_gated(input logic [11:0] a);
    return (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= 2'b00;
    else        s_q <= {s_q[0], 1'b1};
  end

  always @(posedge clk or negedge s_q[1]) begin
    if (!s_q[1]) begin
      m_cyc <= '0; m_ret <= '0; m_mg <= '0; m_sg <= '0;
      e_rdata <= '0; e_ill <= 1'b0;
    end else begin
      logic ill;
      ill = csr_re && f_gated(csr_addr) && !f_allow(priv, m_mg, m_sg)[csr_addr[4:0]];
      e_ill   <= ill;
      e_rdata <= (csr_re && !ill) ? f_data(csr_addr, m_cyc, m_ret, m_mg, m_sg) : 32'h0;
      if (csr_we && csr_addr == 12'h306) m_mg <= csr_wdata;
      if (csr_we && csr_addr == 12'h106) m_sg <= csr_wdata;
      if (csr_we && csr_addr == 12'hB00)      m_cyc <= {m_cyc[63:32], csr_wdata};
      else if (csr_we && csr_addr == 12'hB80) m_cyc <= {csr_wdata, m_cyc[31:0]};
      else                                    m_cyc <= m_cyc + 1;
      if (csr_we && csr_addr == 12'hB02)      m_ret <= {m_ret[63:32], csr_wdata};
      else if (csr_we && csr_addr == 12'hB82) m_ret <= {csr_wdata, m_ret[31:0]};
      else if (retire)                        m_ret <= m_ret + 1;
    end
  end

  task automatic compare(input string tag);
    nchk++;
    if (csr_rdata !== e_rdata || csr_illegal !== e_ill) begin
      nfail++;
      $display("FAIL %s: rdata=%h illegal=%b expected rdata=%h illegal=%b",
               tag, csr_rdata, csr_illegal, e_rdata, e_ill);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare at next falling edge
  task automatic step(input logic [11:0] a, input logic [31:0] wd, input logic we, re,
                      input logic [1:0] pv, input logic ret, input string tag);
    csr_addr = a; csr_wdata = wd; csr_we = we; csr_re = re; priv = pv; retire = ret;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] pv, input string tag);
    step(a, 32'h0, 1'b0, 1'b1, pv, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input string tag);
    step(a, wd, 1'b1, 1'b0, 2'd3, 1'b0, tag);
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_C0DE);
    rst_n = 1'b0;
    csr_addr = '0; csr_wdata = '0; csr_we = 0; csr_re = 0; priv = 2'd3; retire = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    step(12'h000, 0, 0, 0, 2'd3, 0, "R12 reset outputs");
    step(12'h000, 0, 0, 0, 2'd3, 0, "R12 reset outputs");
    rd(12'h306, 2'd3, "R12 mgrant reset");
    rd(12'hB02, 2'd3, "R12 retired reset");
    rd(12'hB00, 2'd3, "R7 cycle running");

    // R2 machine mode ignores masks
    rd(12'hC00, 2'd3, "R2 machine cycle view");
    rd(12'hC02, 2'd3, "R2 machine retired view");
    // R3 supervisor denied with empty masks, R5 flag pulse
    rd(12'hC00, 2'd1, "R3 R5 supervisor denied");
    step(12'h000, 0, 0, 0, 2'd1, 0, "R5 flag drops");

    wr(12'h306, 32'h0000_0005, "R1 write mgrant");
    rd(12'hC00, 2'd1, "R3 supervisor allowed bit0");
    rd(12'hC02, 2'd1, "R3 supervisor allowed bit2");
    rd(12'hC03, 2'd1, "R3 supervisor denied bit3");
    rd(12'hC02, 2'd2, "R3 reserved mode as supervisor");
    rd(12'hC00, 2'd0, "R4 user denied without sgrant");
    wr(12'h106, 32'h0000_0001, "R1 write sgrant");
    rd(12'hC00, 2'd0, "R4 user allowed both bits");
    rd(12'hC02, 2'd0, "R4 user denied sgrant bit2 clear");
    rd(12'h306, 2'd0, "R1 mgrant readback");
    rd(12'h106, 2'd1, "R1 sgrant readback");

    // R8 R9 counter writes
    wr(12'hB00, 32'hFFFF_FFF0, "R8 cycle low write");
    rd(12'hB00, 2'd3, "R8 cycle low after write");
    wr(12'hB80, 32'h1234_5678, "R9 cycle high write");
    rd(12'hB00, 2'd3, "R9 cycle low kept");
    rd(12'hB80, 2'd3, "R9 cycle high read");
    rd(12'hC80, 2'd0, "R9 R4 user high view");
    step(12'hB02, 32'hFFFF_FFFF, 1, 0, 2'd3, 1, "R8 write beats retire");
    rd(12'hB02, 2'd3, "R8 retired after write");
    step(12'h000, 0, 0, 0, 2'd3, 1, "R7 retire pulse");
    rd(12'hB02, 2'd3, "R9 retired low wrapped");
    rd(12'hB82, 2'd3, "R9 retired carry to high");
    step(12'hB82, 32'hAAAA_0001, 1, 0, 2'd3, 1, "R8 high write beats retire");
    rd(12'hB82, 2'd3, "R9 retired high read");

    // R10 R11 unimplemented
    rd(12'hB05, 2'd3, "R10 machine hpm zero");
    rd(12'hB9F, 2'd3, "R10 machine hpm high zero");
    wr(12'h306, 32'hFFFF_FFFF, "R1 open mgrant");
    wr(12'h106, 32'hFFFF_FFFF, "R1 open sgrant");
    rd(12'hC1F, 2'd0, "R10 user hpm zero");
    rd(12'hC83, 2'd1, "R10 user hpm high zero");
    rd(12'hC01, 2'd0, "R10 time index zero");
    wr(12'h323, 32'hDEAD_BEEF, "R11 event write");
    rd(12'h323, 2'd3, "R11 event reads zero");
    rd(12'h33F, 2'd3, "R11 last event zero");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [4:0]  lo;
      lo = 5'($urandom_range(0, 31));
      case ($urandom_range(0, 9))
        0: a = 12'h306;
        1: a = 12'h106;
        2: a = 12'hB00 | {7'h0, lo};
        3: a = 12'hB80 | {7'h0, lo};
        4, 5: a = 12'hC00 | {7'h0, lo};
        6: a = 12'hC80 | {7'h0, lo};
        7: a = 12'h323 + 12'($urandom_range(0, 28));
        8: a = {10'h0, lo[1:0]} | 12'hC00;
        default: a = ($urandom_range(0, 1) != 0) ? 12'hB02 : 12'hB82;
      endcase
      step(a, $urandom, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R3 R4 R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule